// File: doc/BRIEF.md
# Video Memory CPU Access Port

This block sits between a CPU and a 128 KB video memory. The CPU sees two byte-wide ports, selected by a single select line. The control port takes bytes in pairs. A pair either sets the 14-bit low address together with a transfer direction, or writes a value into a numbered control register. The data port moves one byte per strobe between the CPU and the memory. After each byte it steps the address onward.

The 17-bit memory address has two parts. The upper three bits come from a page register, control register 14. The lower fourteen bits come from a counter that the control port loads. In the normal display modes, a carry out of the counter's top bit advances the page register, so a run of data-port accesses can stream across the whole memory. When the legacy mode input is high, the counter wraps inside its own 16 KB window and the page register stays as it is.

A read-direction address setup starts a read right away, so the first data-port read already has its byte. Each later read returns that held byte and fetches the next one. Register writes to numbers other than 14 are passed out on a one-cycle strobe for the rest of the display processor.

Top module: `vram_port_ctrl`

## Requirements
- R1: After reset, mem_req, reg_wr_en and cpu_rdata are all 0. The page register and the counter are 0. The next control-port byte is treated as the first of a pair.
- R2: The first control-port byte of a pair is held. If the second byte has bit 7 = 0, its bits 5..0 become address bits 13..8 and the held byte becomes bits 7..0. Bit 6 of the second byte sets the direction: 1 = write, 0 = read.
- R3: A read-direction setup issues exactly one memory read (mem_req=1, mem_we=0) in the cycle after the second byte, at {page, new address}.
- R4: A data-port read (cpu_rd with cpu_sel=0) puts the byte held from the previous memory read on cpu_rdata one cycle later. In that same cycle it issues a memory read at the current address.
- R5: A data-port write (cpu_wr with cpu_sel=0) issues, one cycle later, a memory write (mem_req=1, mem_we=1) of cpu_wdata at {page, counter}.
- R6: Each memory access (data-port read, data-port write or setup read) advances the 14-bit counter by one.
- R7: When legacy_mode=0 and an access is made at counter value 0x3FFF, the counter wraps to 0 and the page register goes up by one. Page 7 goes to page 0.
- R8: When legacy_mode=1, an access at 0x3FFF wraps the counter to 0 and leaves the page register unchanged.
- R9: A second byte with bit 7 = 1 writes register number bits 5..0, using the held first byte as data. Register 14 takes data bits 2..0 as the page, and its other data bits are ignored. A write to register 14 does not appear on reg_wr_en.
- R10: A write to any other register number gives one cycle of reg_wr_en, carrying that number and data. It makes no memory request and leaves the counter alone.
- R11: Loading an address through the control port never changes the page register.
- R12: After any second byte, whether an address load or a register write, the next control-port byte is again a first byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| legacy_mode | input | 1 | 1 = counter wraps in 16 KB and the page is not advanced |
| cpu_wr | input | 1 | CPU write strobe, one cycle per byte |
| cpu_rd | input | 1 | CPU read strobe, one cycle per byte |
| cpu_sel | input | 1 | Port select: 0 = data port, 1 = control port |
| cpu_wdata | input | 8 | Byte written by the CPU |
| cpu_rdata | output | 8 | Byte returned by data-port reads |
| mem_req | output | 1 | Memory access strobe, one cycle per access |
| mem_we | output | 1 | 1 = write access, 0 = read access |
| mem_addr | output | 17 | Memory byte address {page, counter} |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid the cycle after mem_req |
| reg_wr_en | output | 1 | Strobe for a write to a register other than 14 |
| reg_wr_num | output | 6 | Register number for reg_wr_en |
| reg_wr_data | output | 8 | Register data for reg_wr_en |

## Verification
If the pair toggle is wrong, the next control byte is taken as the other half of a pair. The damage then shows on mem_addr, or as a false reg_wr_en, one cycle after that byte. If the counter or page is wrong, mem_addr is wrong on the very next access strobe. A page that misses a carry shows up across the 0x3FFF boundary. If the read latch is wrong, cpu_rdata is wrong one cycle after the following data-port read. A reference model checks every output on every clock, so each of these faults is seen within a few cycles of the access that exposes it.

// File: rtl/vpc_pkg.sv
package vpc_pkg;
  localparam int VPC_DATA_W  = 8;
  localparam int VPC_LO_W    = 14;
  localparam int VPC_PAGE_W  = 3;
  localparam int VPC_RNUM_W  = 6;
  localparam int VPC_PAGE_RN = 14;

  typedef struct packed {
    logic                  load;      // address pair completed
    logic                  prefetch;  // address pair with read direction
    logic                  reg_wr;    // register pair completed
    logic [VPC_RNUM_W-1:0] reg_num;
    logic [VPC_DATA_W-1:0] reg_data;
    logic [VPC_LO_W-1:0]   addr;
  } vpc_cmd_t;
endpackage

// File: rtl/vpc_ctl_decode.sv
module vpc_ctl_decode
  import vpc_pkg::*;
#(
  parameter int DATA_W = VPC_DATA_W,
  parameter int LO_W   = VPC_LO_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_wr,
  input  logic [DATA_W-1:0] ctl_byte,
  output vpc_cmd_t          cmd
);
  localparam int HI_W    = LO_W - DATA_W;
  localparam int DIR_BIT = DATA_W - 2;
  localparam int REG_BIT = DATA_W - 1;

  logic              second_q;
  logic [DATA_W-1:0] first_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      second_q <= 1'b0;
      first_q  <= '0;
    end else if (ctl_wr) begin
      if (!second_q) begin
        first_q  <= ctl_byte;
        second_q <= 1'b1;
      end else begin
        second_q <= 1'b0;
      end
    end
  end

  logic take;
  logic is_reg;
  assign take   = ctl_wr && second_q;
  assign is_reg = ctl_byte[REG_BIT];

  always_comb begin
    cmd          = '0;
    cmd.load     = take && !is_reg;
    cmd.prefetch = take && !is_reg && !ctl_byte[DIR_BIT];
    cmd.reg_wr   = take && is_reg;
    cmd.reg_num  = ctl_byte[VPC_RNUM_W-1:0];
    cmd.reg_data = first_q;
    cmd.addr     = {ctl_byte[HI_W-1:0], first_q};
  end

  // R12
  pair_close_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && second_q) |=> !second_q);

  // R2
  pair_open_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && !second_q) |=> (second_q && first_q == $past(ctl_byte)));
endmodule

// File: rtl/vpc_addr_gen.sv
module vpc_addr_gen
  import vpc_pkg::*;
#(
  parameter int LO_W = VPC_LO_W,
  parameter int PG_W = VPC_PAGE_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 legacy,
  input  logic                 load,
  input  logic [LO_W-1:0]      load_addr,
  input  logic                 adv,
  input  logic                 page_wr,
  input  logic [PG_W-1:0]      page_val,
  output logic [LO_W+PG_W-1:0] acc_addr
);
  logic [LO_W-1:0] cnt_q;
  logic [PG_W-1:0] page_q;
  logic [LO_W-1:0] base;
  logic            wrap;

  assign base     = load ? load_addr : cnt_q;
  assign wrap     = &base;
  assign acc_addr = {page_q, base};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      page_q <= '0;
    end else begin
      if (page_wr)
        page_q <= page_val;
      else if (adv && wrap && !legacy)
        page_q <= page_q + 1'b1;
      if (adv)
        cnt_q <= base + 1'b1;
      else if (load)
        cnt_q <= load_addr;
    end
  end

  // R6
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && !wrap) |=> (cnt_q == $past(base) + 1'b1));

  // R7
  page_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && wrap && !legacy && !page_wr) |=> (page_q == PG_W'($past(page_q) + 1'b1) && cnt_q == '0));

  // R8
  legacy_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && wrap && legacy && !page_wr) |=> ($stable(page_q) && cnt_q == '0));

  // R11
  load_keeps_page_chk: assert property (@(posedge clk) disable iff (rst)
    (load && !adv && !page_wr) |=> $stable(page_q));
endmodule

// File: rtl/vpc_mem_port.sv
module vpc_mem_port
  import vpc_pkg::*;
#(
  parameter int DATA_W = VPC_DATA_W,
  parameter int ADDR_W = VPC_LO_W + VPC_PAGE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_go,
  input  logic              acc_we,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  input  logic              cpu_rd_go,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [DATA_W-1:0] cpu_rdata
);
  logic              rd_wait;
  logic [DATA_W-1:0] latch_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      rd_wait   <= 1'b0;
      latch_q   <= '0;
      cpu_rdata <= '0;
    end else begin
      mem_req <= acc_go;
      if (acc_go) begin
        mem_we   <= acc_we;
        mem_addr <= acc_addr;
        if (acc_we)
          mem_wdata <= acc_wdata;
      end
      rd_wait <= mem_req && !mem_we;
      if (rd_wait)
        latch_q <= mem_rdata;
      if (cpu_rd_go)
        cpu_rdata <= rd_wait ? mem_rdata : latch_q;
    end
  end

  // R5
  write_issue_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_go && acc_we) |=> (mem_req && mem_we && mem_wdata == $past(acc_wdata)));

  // R4
  read_return_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd_go && !rd_wait) |=> (cpu_rdata == $past(latch_q)));

  // R3
  read_issue_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_go && !acc_we) |=> (mem_req && !mem_we && mem_addr == $past(acc_addr)));
endmodule

// File: rtl/vram_port_ctrl.sv
module vram_port_ctrl
  import vpc_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          legacy_mode,
  input  logic                          cpu_wr,
  input  logic                          cpu_rd,
  input  logic                          cpu_sel,
  input  logic [VPC_DATA_W-1:0]         cpu_wdata,
  output logic [VPC_DATA_W-1:0]         cpu_rdata,
  output logic                          mem_req,
  output logic                          mem_we,
  output logic [VPC_LO_W+VPC_PAGE_W-1:0] mem_addr,
  output logic [VPC_DATA_W-1:0]         mem_wdata,
  input  logic [VPC_DATA_W-1:0]         mem_rdata,
  output logic                          reg_wr_en,
  output logic [VPC_RNUM_W-1:0]         reg_wr_num,
  output logic [VPC_DATA_W-1:0]         reg_wr_data
);
  localparam int ADDR_W = VPC_LO_W + VPC_PAGE_W;
  localparam logic [VPC_RNUM_W-1:0] PAGE_RN = VPC_RNUM_W'(VPC_PAGE_RN);

  logic              ctl_wr, data_wr, data_rd;
  logic              acc_go, page_wr, other_reg;
  logic [ADDR_W-1:0] acc_addr;
  vpc_cmd_t          cmd;

  assign ctl_wr  = cpu_wr && cpu_sel;
  assign data_wr = cpu_wr && !cpu_sel;
  assign data_rd = cpu_rd && !cpu_wr && !cpu_sel;

  vpc_ctl_decode #(.DATA_W(VPC_DATA_W), .LO_W(VPC_LO_W)) u_decode (
    .clk      (clk),
    .rst      (rst),
    .ctl_wr   (ctl_wr),
    .ctl_byte (cpu_wdata),
    .cmd      (cmd)
  );

  assign page_wr   = cmd.reg_wr && (cmd.reg_num == PAGE_RN);
  assign other_reg = cmd.reg_wr && (cmd.reg_num != PAGE_RN);
  assign acc_go    = data_wr || data_rd || cmd.prefetch;

  vpc_addr_gen #(.LO_W(VPC_LO_W), .PG_W(VPC_PAGE_W)) u_addr (
    .clk       (clk),
    .rst       (rst),
    .legacy    (legacy_mode),
    .load      (cmd.load),
    .load_addr (cmd.addr),
    .adv       (acc_go),
    .page_wr   (page_wr),
    .page_val  (cmd.reg_data[VPC_PAGE_W-1:0]),
    .acc_addr  (acc_addr)
  );

  vpc_mem_port #(.DATA_W(VPC_DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .clk       (clk),
    .rst       (rst),
    .acc_go    (acc_go),
    .acc_we    (data_wr),
    .acc_addr  (acc_addr),
    .acc_wdata (cpu_wdata),
    .cpu_rd_go (data_rd),
    .mem_rdata (mem_rdata),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .cpu_rdata (cpu_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_wr_en   <= 1'b0;
      reg_wr_num  <= '0;
      reg_wr_data <= '0;
    end else begin
      reg_wr_en <= other_reg;
      if (other_reg) begin
        reg_wr_num  <= cmd.reg_num;
        reg_wr_data <= cmd.reg_data;
      end
    end
  end

  // R10
  reg_no_mem_chk: assert property (@(posedge clk) disable iff (rst)
    reg_wr_en |-> !mem_req);

  // R9
  page_not_exported_chk: assert property (@(posedge clk) disable iff (rst)
    reg_wr_en |-> (reg_wr_num != PAGE_RN));
endmodule

// File: tb/vram_port_ctrl_tb.sv
module vram_port_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       legacy_mode = 1'b0;
  logic       cpu_wr = 1'b0, cpu_rd = 1'b0, cpu_sel = 1'b0;
  logic [7:0] cpu_wdata = 8'h00;
  logic [7:0] cpu_rdata;
  logic       mem_req, mem_we;
  logic [16:0] mem_addr;
  logic [7:0] mem_wdata;
  logic [7:0] mem_rdata = 8'h00;
  logic       reg_wr_en;
  logic [5:0] reg_wr_num;
  logic [7:0] reg_wr_data;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vram_port_ctrl u_dut (
    .clk(clk), .rst(rst), .legacy_mode(legacy_mode),
    .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_sel(cpu_sel),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .reg_wr_en(reg_wr_en), .reg_wr_num(reg_wr_num), .reg_wr_data(reg_wr_data)
  );

  function automatic int pat(int a);
    return ((a * 13) + (a >> 8) + 5) & 255;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- bench memory and request recorder ----------------
  int ram[int];
  int last_addr = -1, last_we = -1, last_wdata = -1;
  int req_count = 0, rwen_count = 0, last_rnum = -1, last_rdat = -1;

  always @(posedge clk) begin
    if (mem_req) begin
      req_count++;
      last_addr = int'(mem_addr);
      last_we   = int'(mem_we);
      if (mem_we) begin
        ram[int'(mem_addr)] = int'(mem_wdata);
        last_wdata = int'(mem_wdata);
      end else begin
        mem_rdata <= 8'(ram.exists(int'(mem_addr)) ? ram[int'(mem_addr)] : pat(int'(mem_addr)));
      end
    end
    if (reg_wr_en) begin
      rwen_count++;
      last_rnum = int'(reg_wr_num);
      last_rdat = int'(reg_wr_data);
    end
  end

  // ---------------- behavioural reference model ----------------
  int ref_mem[int];
  bit m_tog = 0;
  int m_first = 0, m_cnt = 0, m_page = 0, m_latch = 0;
  bit m_req = 0, m_we = 0, m_rwen = 0;
  int m_addr = 0, m_wdata = 0, m_rdata = 0, m_rnum = 0, m_rdat = 0;

  task automatic model_access(bit we, int d);
    m_req  = 1;
    m_we   = we;
    m_addr = m_page * 16384 + m_cnt;
    if (we) begin
      ref_mem[m_addr] = d;
      m_wdata = d;
    end else begin
      m_latch = ref_mem.exists(m_addr) ? ref_mem[m_addr] : pat(m_addr);
    end
    m_cnt++;
    if (m_cnt == 16384) begin
      m_cnt = 0;
      if (!legacy_mode) m_page = (m_page + 1) % 8;
    end
  endtask

  always @(posedge clk) begin
    m_req  = 0;
    m_rwen = 0;
    if (rst) begin
      m_tog = 0; m_first = 0; m_cnt = 0; m_page = 0; m_latch = 0; m_rdata = 0;
    end else if (cpu_wr && cpu_sel) begin
      if (!m_tog) begin
        m_first = int'(cpu_wdata);
        m_tog = 1;
      end else begin
        m_tog = 0;
        if (cpu_wdata[7]) begin
          if (int'(cpu_wdata[5:0]) == 14) m_page = m_first % 8;
          else begin
            m_rwen = 1;
            m_rnum = int'(cpu_wdata[5:0]);
            m_rdat = m_first;
          end
        end else begin
          m_cnt = int'(cpu_wdata[5:0]) * 256 + m_first;
          if (!cpu_wdata[6]) model_access(0, 0);
        end
      end
    end else if (cpu_wr) begin
      model_access(1, int'(cpu_wdata));
    end else if (cpu_rd && !cpu_sel) begin
      m_rdata = m_latch;
      model_access(0, 0);
    end
  end

  // per-clock comparison
  always @(negedge clk) begin
    if (!rst && !done) begin
      check(mem_req == m_req, "R3 mem_req", int'(mem_req), int'(m_req));
      if (m_req) begin
        check(int'(mem_addr) == m_addr, "R6 mem_addr", int'(mem_addr), m_addr);
        check(mem_we == m_we, "R5 mem_we", int'(mem_we), int'(m_we));
        if (m_we) check(int'(mem_wdata) == m_wdata, "R5 mem_wdata", int'(mem_wdata), m_wdata);
      end
      check(int'(cpu_rdata) == m_rdata, "R4 cpu_rdata", int'(cpu_rdata), m_rdata);
      check(reg_wr_en == m_rwen, "R10 reg_wr_en", int'(reg_wr_en), int'(m_rwen));
      if (m_rwen) begin
        check(int'(reg_wr_num) == m_rnum, "R10 reg_wr_num", int'(reg_wr_num), m_rnum);
        check(int'(reg_wr_data) == m_rdat, "R10 reg_wr_data", int'(reg_wr_data), m_rdat);
      end
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic gap();
    repeat (3) @(negedge clk);
  endtask

  task automatic ctl(input logic [7:0] b);
    @(negedge clk);
    cpu_wr = 1; cpu_sel = 1; cpu_wdata = b;
    @(negedge clk);
    cpu_wr = 0; cpu_sel = 0;
    gap();
  endtask

  task automatic dwrite(input logic [7:0] b);
    @(negedge clk);
    cpu_wr = 1; cpu_sel = 0; cpu_wdata = b;
    @(negedge clk);
    cpu_wr = 0;
    gap();
  endtask

  task automatic dread();
    @(negedge clk);
    cpu_rd = 1; cpu_sel = 0;
    @(negedge clk);
    cpu_rd = 0;
    gap();
  endtask

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // ---------------- test sequence ----------------
  initial begin
    int rc;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check(mem_req == 0, "R1 mem_req", int'(mem_req), 0);
    check(reg_wr_en == 0, "R1 reg_wr_en", int'(reg_wr_en), 0);
    check(cpu_rdata == 0, "R1 cpu_rdata", int'(cpu_rdata), 0);

    // R2 / R5 / R6: write setup at 0x1234, page 0
    ctl(8'h34); ctl(8'h52);
    dwrite(8'hA5);
    check(last_addr == 'h01234 && last_we == 1, "R5 write addr", last_addr, 'h01234);
    check(last_wdata == 'hA5, "R5 write data", last_wdata, 'hA5);
    dwrite(8'h5A);
    check(last_addr == 'h01235, "R6 step", last_addr, 'h01235);

    // R9 page=2; R11 address load keeps page; R7 carry into page 3
    ctl(8'h02); ctl(8'h8E);
    ctl(8'hFE); ctl(8'h7F);
    dwrite(8'h11);
    check(last_addr == 'h0BFFE, "R11 page kept", last_addr, 'h0BFFE);
    dwrite(8'h22);
    dwrite(8'h33);
    check(last_addr == 'h0C000, "R7 carry", last_addr, 'h0C000);

    // R3 read setup at {3,3FFF}: prefetch, then page advances to 4
    rc = req_count;
    ctl(8'hFF); ctl(8'h3F);
    check(req_count == rc + 1 && last_we == 0, "R3 one prefetch", req_count - rc, 1);
    check(last_addr == 'h0FFFF, "R3 prefetch addr", last_addr, 'h0FFFF);
    dread();
    check(int'(cpu_rdata) == pat('h0FFFF), "R4 first read", int'(cpu_rdata), pat('h0FFFF));
    dread();
    check(int'(cpu_rdata) == pat('h10000), "R4 read after carry", int'(cpu_rdata), pat('h10000));

    // read back written bytes at page 0
    ctl(8'h00); ctl(8'h8E);
    ctl(8'h34); ctl(8'h12);
    dread();
    check(cpu_rdata == 8'hA5, "R4 readback 0", int'(cpu_rdata), 'hA5);
    dread();
    check(cpu_rdata == 8'h5A, "R4 readback 1", int'(cpu_rdata), 'h5A);

    // R8 legacy wrap on page 5
    legacy_mode = 1;
    ctl(8'h05); ctl(8'h8E);
    ctl(8'hFF); ctl(8'h7F);
    dwrite(8'h77);
    check(last_addr == 'h17FFF, "R8 before wrap", last_addr, 'h17FFF);
    dwrite(8'h88);
    check(last_addr == 'h14000, "R8 legacy wrap", last_addr, 'h14000);

    // R7 page 7 -> 0; R9 upper data bits of page write ignored
    legacy_mode = 0;
    ctl(8'hFF); ctl(8'h8E);
    ctl(8'hFF); ctl(8'h7F);
    dwrite(8'h01);
    check(last_addr == 'h1FFFF, "R9 page masked", last_addr, 'h1FFFF);
    dwrite(8'h02);
    check(last_addr == 'h00000, "R7 page wrap", last_addr, 'h00000);

    // R10 other register write; R12 toggle back to first byte
    rc = req_count;
    ctl(8'h5A); ctl(8'h87);
    check(rwen_count == 1 && last_rnum == 7, "R10 reg num", last_rnum, 7);
    check(last_rdat == 'h5A, "R10 reg data", last_rdat, 'h5A);
    check(req_count == rc, "R10 no memory access", req_count - rc, 0);
    dwrite(8'h44);
    check(last_addr == 'h00001, "R10 counter untouched", last_addr, 'h00001);
    ctl(8'h10); ctl(8'h40);
    dwrite(8'h99);
    check(last_addr == 'h00010, "R12 pair restart", last_addr, 'h00010);

    // mixed random traffic, compared every clock against the model
    for (int i = 0; i < 600; i++) begin
      int k;
      k = int'($urandom_range(0, 9));
      if (k == 9) legacy_mode = ~legacy_mode;
      else if (k < 4) ctl(8'($urandom));
      else if (k < 7) dwrite(8'($urandom));
      else dread();
    end

    repeat (4) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule